// File: doc/BRIEF.md
# Hit-under-miss load scoreboard

This block lets an in-order pipeline keep issuing instructions while one data-cache miss is outstanding. The first miss goes through MEM without stopping the pipeline. The block records that miss in a single slot beside the pipeline, issues the line request to memory and waits for the refill there. While the miss is outstanding, the load's destination register is held busy in a per-register record. An instruction in EX is stalled only if it reads or writes that register. Every other instruction keeps flowing.

A second load or store miss that arrives while the slot is taken holds MEM and EX. It stays held until the first refill has been consumed. On the next cycle the freed slot takes the second miss, using the destination and address that the stalled MEM stage is still presenting. A refill writes the register file in the cycle it arrives and has priority over the normal pipeline writeback. In that cycle the pipeline is told to hold its writeback for one cycle.

The memory request is a valid/ready stream. Once `mreq_valid` rises, it and `mreq_addr` stay fixed until a cycle in which `mreq_ready` is high. The refill return is a valid-only stream that the block always accepts while a request is outstanding, so memory must never present it at any other time. The pipeline writeback port is back-pressured by `pwb_hold`. While `pwb_hold` is high, the source keeps the same writeback presented.

Top module: `hum_scoreboard`

## Requirements
- R1: A load or store miss in MEM (mem_valid=1, mem_miss=1, with mem_is_load=1 or mem_is_store=1) while no miss is outstanding gives mem_stall=0. On the next cycle mreq_valid=1 with mreq_addr equal to that access's mem_addr.
- R2: After a load miss to register n (n≠0) is taken, an EX instruction (ex_valid=1) that reads n through rs1 or rs2 gives ex_stall=1. This holds from the cycle the load is in MEM up to and including the cycle its refill arrives. The stall is released on the next cycle.
- R3: An EX instruction that writes (ex_rd_wr=1) a busy register gives ex_stall=1.
- R4: While a miss is outstanding, an EX instruction that touches no busy register gives ex_stall=0.
- R5: A load or store miss in MEM while a miss is outstanding gives mem_stall=1 and ex_stall=1, up to and including the refill cycle of the first miss. On the next cycle it is taken (mem_stall=0). Its address is then requested, its destination becomes busy, and its refill writes that destination.
- R6: When refill data arrives for a load miss, rf_we=1 in the same cycle, with rf_waddr equal to the load's destination and rf_wdata equal to rfl_data. A refill for a store miss writes nothing.
- R7: Register 0 is never busy. EX reads or writes of register 0 never stall, and a refill for a load to register 0 gives rf_we=0.
- R8: When a refill write and pwb_valid coincide, the refill is written and pwb_hold=1. Otherwise pwb_valid=1 writes pwb_rd/pwb_data in the same cycle with pwb_hold=0.
- R9: mreq_valid and mreq_addr stay stable while mreq_ready=0. mreq_valid drops on the cycle after the request is accepted.
- R10: rfl_valid in a cycle when no request is awaiting refill is ignored (rf_we=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Instruction present in EX |
| ex_rs1 | input | 5 | EX first source register |
| ex_rs1_used | input | 1 | First source is read |
| ex_rs2 | input | 5 | EX second source register |
| ex_rs2_used | input | 1 | Second source is read |
| ex_rd | input | 5 | EX destination register |
| ex_rd_wr | input | 1 | EX instruction writes ex_rd |
| mem_valid | input | 1 | Access present in MEM |
| mem_is_load | input | 1 | MEM access is a load |
| mem_is_store | input | 1 | MEM access is a store |
| mem_miss | input | 1 | MEM access missed the cache |
| mem_rd | input | 5 | Load destination register |
| mem_addr | input | 32 | Access address |
| ex_stall | output | 1 | Hold EX |
| mem_stall | output | 1 | Hold MEM |
| mreq_valid | output | 1 | Miss request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Miss request address |
| rfl_valid | input | 1 | Refill data present |
| rfl_data | input | 32 | Refill data |
| pwb_valid | input | 1 | Pipeline writeback present |
| pwb_rd | input | 5 | Pipeline writeback register |
| pwb_data | input | 32 | Pipeline writeback data |
| pwb_hold | output | 1 | Pipeline writeback not taken this cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | 32 | Register file write data |

## Verification
The bench builds the block with its defaults: 32 registers, 32-bit data and 32-bit addresses. This gives real five-bit register compares, with register 0 and high-numbered registers such as 20 both in use. A memory model returns each refill 20 cycles after the request. The long window lets the bench place independent instructions, source and destination hazards, and a held request under the miss. The model also flags the cycle before each refill, so a pipeline writeback can be made to collide with it. The store-then-load sequence checks the stalled second miss, the freed slot taking it over and its destination register being written.

// File: rtl/hum_pkg.sv
package hum_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_REQ  = 2'd1,
    SLOT_WAIT = 2'd2
  } slot_state_e;

  typedef struct packed {
    logic       is_load;
    logic [4:0] rd;
  } slot_tag_t;
endpackage

// File: rtl/hum_miss_slot.sv
module hum_miss_slot
  import hum_pkg::*;
#(
  parameter int RW = 5,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          alloc_has_rd,
  input  logic [RW-1:0] alloc_rd,
  input  logic [AW-1:0] alloc_addr,
  input  logic          mreq_ready,
  input  logic          rfl_valid,
  output logic          occupied,
  output logic          mreq_valid,
  output logic [AW-1:0] mreq_addr,
  output logic          rfl_accept,
  output logic          slot_has_rd,
  output logic [RW-1:0] slot_rd
);
  slot_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] rd_q;
  logic          has_rd_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SLOT_IDLE: if (alloc) state_d = SLOT_REQ;
      SLOT_REQ:  if (mreq_ready) state_d = SLOT_WAIT;
      SLOT_WAIT: if (rfl_valid) state_d = SLOT_IDLE;
      default:   state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SLOT_IDLE;
      addr_q   <= '0;
      rd_q     <= '0;
      has_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SLOT_IDLE && alloc) begin
        addr_q   <= alloc_addr;
        rd_q     <= alloc_rd;
        has_rd_q <= alloc_has_rd;
      end
    end
  end

  assign occupied    = (state_q != SLOT_IDLE);
  assign mreq_valid  = (state_q == SLOT_REQ);
  assign mreq_addr   = addr_q;
  assign rfl_accept  = (state_q == SLOT_WAIT) && rfl_valid;
  assign slot_has_rd = has_rd_q;
  assign slot_rd     = rd_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid);
endmodule

// File: rtl/hum_busy_vec.sv
module hum_busy_vec #(
  parameter int NREGS = 32,
  localparam int RW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [RW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [RW-1:0]    clr_idx,
  output logic [NREGS-1:0] busy
);
  assign busy[0] = 1'b0;

  for (genvar g = 1; g < NREGS; g++) begin : g_entry
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else if (set_en && set_idx == RW'(g)) bit_q <= 1'b1;
      else if (clr_en && clr_idx == RW'(g)) bit_q <= 1'b0;
    end
    assign busy[g] = bit_q;
  end

  // R5
  single_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));

  // R7
  zero_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (set_idx != '0));
endmodule

// File: rtl/hum_hazard.sv
module hum_hazard #(
  parameter int NREGS = 32,
  localparam int RW = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] busy,
  input  logic             alloc_hit,
  input  logic [RW-1:0]    alloc_rd,
  input  logic             ex_valid,
  input  logic [RW-1:0]    ex_rs1,
  input  logic             ex_rs1_used,
  input  logic [RW-1:0]    ex_rs2,
  input  logic             ex_rs2_used,
  input  logic [RW-1:0]    ex_rd,
  input  logic             ex_rd_wr,
  output logic             hazard
);
  localparam int NOPS = 3;

  logic [RW-1:0] op_idx [NOPS];
  logic [NOPS-1:0] op_use;
  logic [NOPS-1:0] op_block;

  assign op_idx[0] = ex_rs1;
  assign op_idx[1] = ex_rs2;
  assign op_idx[2] = ex_rd;
  assign op_use    = {ex_rd_wr, ex_rs2_used, ex_rs1_used};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic nonzero;
    assign nonzero     = (op_idx[g] != '0);
    assign op_block[g] = op_use[g] && nonzero &&
                         (busy[op_idx[g]] || (alloc_hit && alloc_rd == op_idx[g]));
  end

  assign hazard = ex_valid && (|op_block);
endmodule

// File: rtl/hum_wb_arb.sv
module hum_wb_arb #(
  parameter int RW   = 5,
  parameter int XLEN = 32
) (
  input  logic            refill_we,
  input  logic [RW-1:0]   refill_rd,
  input  logic [XLEN-1:0] refill_data,
  input  logic            pwb_valid,
  input  logic [RW-1:0]   pwb_rd,
  input  logic [XLEN-1:0] pwb_data,
  output logic            pwb_hold,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata
);
  always_comb begin
    pwb_hold = 1'b0;
    rf_we    = 1'b0;
    rf_waddr = '0;
    rf_wdata = '0;
    if (refill_we) begin
      rf_we    = 1'b1;
      rf_waddr = refill_rd;
      rf_wdata = refill_data;
      pwb_hold = pwb_valid;
    end else if (pwb_valid) begin
      rf_we    = 1'b1;
      rf_waddr = pwb_rd;
      rf_wdata = pwb_data;
    end
  end
endmodule

// File: rtl/hum_scoreboard.sv
module hum_scoreboard
  import hum_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int AW    = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [RW-1:0]   ex_rs1,
  input  logic            ex_rs1_used,
  input  logic [RW-1:0]   ex_rs2,
  input  logic            ex_rs2_used,
  input  logic [RW-1:0]   ex_rd,
  input  logic            ex_rd_wr,
  input  logic            mem_valid,
  input  logic            mem_is_load,
  input  logic            mem_is_store,
  input  logic            mem_miss,
  input  logic [RW-1:0]   mem_rd,
  input  logic [AW-1:0]   mem_addr,
  output logic            ex_stall,
  output logic            mem_stall,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic [AW-1:0]   mreq_addr,
  input  logic            rfl_valid,
  input  logic [XLEN-1:0] rfl_data,
  input  logic            pwb_valid,
  input  logic [RW-1:0]   pwb_rd,
  input  logic [XLEN-1:0] pwb_data,
  output logic            pwb_hold,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata
);
  logic             miss_seen, occupied, alloc, alloc_has_rd, alloc_hit;
  logic             rfl_accept, slot_has_rd, refill_we, hazard;
  logic [RW-1:0]    slot_rd;
  logic [NREGS-1:0] busy;

  assign miss_seen    = mem_valid && mem_miss && (mem_is_load || mem_is_store);
  assign alloc        = miss_seen && !occupied;
  assign alloc_has_rd = mem_is_load && (mem_rd != '0);
  assign alloc_hit    = alloc && alloc_has_rd;
  assign mem_stall    = miss_seen && occupied;
  assign refill_we    = rfl_accept && slot_has_rd;
  assign ex_stall     = mem_stall || hazard;

  hum_miss_slot #(.RW(RW), .AW(AW)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc       (alloc),
    .alloc_has_rd(alloc_has_rd),
    .alloc_rd    (mem_rd),
    .alloc_addr  (mem_addr),
    .mreq_ready  (mreq_ready),
    .rfl_valid   (rfl_valid),
    .occupied    (occupied),
    .mreq_valid  (mreq_valid),
    .mreq_addr   (mreq_addr),
    .rfl_accept  (rfl_accept),
    .slot_has_rd (slot_has_rd),
    .slot_rd     (slot_rd)
  );

  hum_busy_vec #(.NREGS(NREGS)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (alloc_hit),
    .set_idx(mem_rd),
    .clr_en (refill_we),
    .clr_idx(slot_rd),
    .busy   (busy)
  );

  hum_hazard #(.NREGS(NREGS)) u_haz (
    .busy       (busy),
    .alloc_hit  (alloc_hit),
    .alloc_rd   (mem_rd),
    .ex_valid   (ex_valid),
    .ex_rs1     (ex_rs1),
    .ex_rs1_used(ex_rs1_used),
    .ex_rs2     (ex_rs2),
    .ex_rs2_used(ex_rs2_used),
    .ex_rd      (ex_rd),
    .ex_rd_wr   (ex_rd_wr),
    .hazard     (hazard)
  );

  hum_wb_arb #(.RW(RW), .XLEN(XLEN)) u_arb (
    .refill_we  (refill_we),
    .refill_rd  (slot_rd),
    .refill_data(rfl_data),
    .pwb_valid  (pwb_valid),
    .pwb_rd     (pwb_rd),
    .pwb_data   (pwb_data),
    .pwb_hold   (pwb_hold),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
  );

  // R5
  mem_hold_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> ex_stall);

  // R8
  refill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_we && pwb_valid) |-> (pwb_hold && rf_waddr == slot_rd && rf_wdata == rfl_data));

  // R2
  busy_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_we |=> (busy == '0));

  // R10
  stray_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfl_valid && !occupied) |-> (rf_we == pwb_valid));
endmodule

// File: tb/hum_scoreboard_bench.sv
`timescale 1ns/1ps
module hum_scoreboard_bench;
  localparam int LAT = 20;

  typedef struct packed {
    logic [4:0]  r;
    logic [31:0] d;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_valid = 0, ex_rs1_used = 0, ex_rs2_used = 0, ex_rd_wr = 0;
  logic [4:0] ex_rs1 = 0, ex_rs2 = 0, ex_rd = 0, mem_rd = 0, pwb_rd = 0;
  logic mem_valid = 0, mem_is_load = 0, mem_is_store = 0, mem_miss = 0;
  logic [31:0] mem_addr = 0, rfl_data = 0, pwb_data = 0;
  logic mreq_ready = 1, rfl_valid = 0, pwb_valid = 0, rfl_soon = 0;
  logic ex_stall, mem_stall, mreq_valid, pwb_hold, rf_we;
  logic [31:0] mreq_addr, rf_wdata;
  logic [4:0] rf_waddr;

  int checks = 0, errors = 0;
  wr_item_t expq[$];

  always #2.5 clk = ~clk;

  hum_scoreboard u_hum_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .ex_valid(ex_valid), .ex_rs1(ex_rs1), .ex_rs1_used(ex_rs1_used),
    .ex_rs2(ex_rs2), .ex_rs2_used(ex_rs2_used), .ex_rd(ex_rd), .ex_rd_wr(ex_rd_wr),
    .mem_valid(mem_valid), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .mem_miss(mem_miss), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .ex_stall(ex_stall), .mem_stall(mem_stall),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .rfl_valid(rfl_valid), .rfl_data(rfl_data),
    .pwb_valid(pwb_valid), .pwb_rd(pwb_rd), .pwb_data(pwb_data), .pwb_hold(pwb_hold),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  function automatic logic [31:0] line_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic push_exp(input logic [4:0] r, input logic [31:0] d);
    expq.push_back('{r: r, d: d});
  endtask

  task automatic ex_set(input logic v, input logic [4:0] s1, input logic u1,
                        input logic [4:0] s2, input logic u2,
                        input logic [4:0] d, input logic w);
    ex_valid = v; ex_rs1 = s1; ex_rs1_used = u1;
    ex_rs2 = s2; ex_rs2_used = u2; ex_rd = d; ex_rd_wr = w;
  endtask

  task automatic mem_set(input logic v, input logic ld, input logic st,
                         input logic [4:0] d, input logic [31:0] a);
    mem_valid = v; mem_is_load = ld; mem_is_store = st; mem_miss = v;
    mem_rd = d; mem_addr = a;
  endtask

  task automatic wait_pre_refill();
    do begin
      @(negedge clk);
      #1;
    end while (!rfl_soon);
  endtask

  // memory model: fixed latency refill
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && mreq_valid && mreq_ready) begin
        a = mreq_addr;
        repeat (LAT - 1) @(negedge clk);
        rfl_soon = 1'b1;
        @(negedge clk);
        rfl_soon  = 1'b0;
        rfl_valid = 1'b1;
        rfl_data  = line_word(a);
        @(negedge clk);
        rfl_valid = 1'b0;
      end
    end
  end

  // monitor: compare every register file write with the expected queue
  initial begin
    wr_item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rf_we) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R6/R8 unexpected write: actual r%0d=%0h expected none", rf_waddr, rf_wdata);
        end else begin
          it = expq.pop_front();
          if (rf_waddr !== it.r || rf_wdata !== it.d) begin
            errors++;
            $display("FAIL R6/R8 write: actual r%0d=%0h expected r%0d=%0h",
                     rf_waddr, rf_wdata, it.r, it.d);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    settle();
    chk("reset ex_stall", ex_stall, 0);
    chk("reset mem_stall", mem_stall, 0);
    chk("reset mreq_valid", mreq_valid, 0);
    chk("reset rf_we", rf_we, 0);
    tick(); rst_n = 1'b1;

    // R1 R2: load miss to r5 with a reader of r5 in EX the same cycle
    tick(); mem_set(1, 1, 0, 5'd5, 32'h100); ex_set(1, 5'd5, 1, 5'd0, 0, 5'd0, 0);
    push_exp(5'd5, line_word(32'h100));
    settle();
    chk("R1 first miss mem_stall", mem_stall, 0);
    chk("R2 same-cycle reader", ex_stall, 1);
    tick(); mem_set(0, 0, 0, 0, 0); mreq_ready = 0; ex_set(1, 5'd6, 1, 5'd7, 1, 5'd8, 1);
    settle();
    chk("R1 mreq_valid", mreq_valid, 1);
    chk("R1 mreq_addr", mreq_addr, 32'h100);
    chk("R4 independent", ex_stall, 0);
    tick(); ex_set(1, 5'd1, 1, 5'd2, 1, 5'd5, 1);
    settle();
    chk("R9 held valid", mreq_valid, 1);
    chk("R9 held addr", mreq_addr, 32'h100);
    chk("R3 writer of busy", ex_stall, 1);
    tick(); mreq_ready = 1; ex_set(1, 5'd3, 1, 5'd5, 1, 5'd0, 0);
    settle();
    chk("R2 rs2 reader", ex_stall, 1);
    tick(); settle();
    chk("R9 drop after accept", mreq_valid, 0);
    wait_pre_refill();
    tick(); settle();
    chk("R6 refill we", rf_we, 1);
    chk("R2 refill cycle still stalled", ex_stall, 1);
    tick(); settle();
    chk("R2 released", ex_stall, 0);
    ex_set(0, 0, 0, 0, 0, 0, 0);

    // R7: load miss to r0
    tick(); mem_set(1, 1, 0, 5'd0, 32'h200); ex_set(1, 5'd0, 1, 5'd0, 1, 5'd0, 1);
    settle();
    chk("R7 r0 same cycle", ex_stall, 0);
    tick(); mem_set(0, 0, 0, 0, 0);
    settle();
    chk("R7 r0 later", ex_stall, 0);
    wait_pre_refill();
    tick(); settle();
    chk("R7 no r0 write", rf_we, 0);
    ex_set(0, 0, 0, 0, 0, 0, 0);

    // R5: store miss, then a load miss to r9 that must wait
    tick(); mem_set(1, 0, 1, 5'd0, 32'h300);
    settle();
    chk("R5 store taken", mem_stall, 0);
    tick(); mem_set(1, 1, 0, 5'd9, 32'h400); ex_set(1, 5'd9, 1, 5'd0, 0, 5'd0, 0);
    settle();
    chk("R5 second miss mem_stall", mem_stall, 1);
    chk("R5 second miss ex_stall", ex_stall, 1);
    wait_pre_refill();
    tick(); settle();
    chk("R6 store refill no write", rf_we, 0);
    chk("R5 refill cycle still held", mem_stall, 1);
    tick(); settle();
    chk("R5 taken after refill", mem_stall, 0);
    chk("R5 r9 hazard on take", ex_stall, 1);
    push_exp(5'd9, line_word(32'h400));
    tick(); mem_set(0, 0, 0, 0, 0);
    settle();
    chk("R5 mreq addr", mreq_addr, 32'h400);
    chk("R5 r9 busy", ex_stall, 1);
    wait_pre_refill();
    tick(); settle();
    chk("R5 r9 written", rf_we, 1);
    ex_set(0, 0, 0, 0, 0, 0, 0);

    // R8: plain writeback, then a collision with a refill
    tick(); pwb_valid = 1; pwb_rd = 5'd17; pwb_data = 32'h1234;
    push_exp(5'd17, 32'h1234);
    settle();
    chk("R8 plain writeback no hold", pwb_hold, 0);
    tick(); pwb_valid = 0; mem_set(1, 1, 0, 5'd12, 32'h500);
    push_exp(5'd12, line_word(32'h500));
    tick(); mem_set(0, 0, 0, 0, 0);
    wait_pre_refill();
    tick(); pwb_valid = 1; pwb_rd = 5'd20; pwb_data = 32'hCAFE;
    push_exp(5'd20, 32'hCAFE);
    settle();
    chk("R8 hold on collision", pwb_hold, 1);
    chk("R8 refill address wins", rf_waddr, 12);
    tick(); settle();
    chk("R8 held writeback goes", pwb_hold, 0);
    tick(); pwb_valid = 0;

    // R10: refill with nothing outstanding
    tick(); rfl_valid = 1; rfl_data = 32'hDEAD;
    settle();
    chk("R10 stray refill", rf_we, 0);
    tick(); rfl_valid = 0;
    repeat (2) tick();
    settle();
    chk("R6 all writes seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule